// File: doc/BRIEF.md
# Flash Bus Write Gate and Reset Sequencer

This block is the pin-side control front end of a parallel NOR-style flash device. It receives the active-low chip-enable, output-enable and write-enable pins, the active-low hardware reset pin and a digital flag from the supply monitor. From them it makes four things: a single-cycle write strobe for the command state machine, a reset request for that state machine, an enable for the tristate data drivers, and a ready indication that tells whether the device can be accessed. All pin inputs are synchronised to the internal clock. The enable pins then pass through a glitch filter, so a low pulse that is too short cannot start a write.

A hardware reset is timed in clock cycles. A low pulse on the reset pin must last a minimum width before it counts. The command state machine is then reset a fixed delay after the falling edge, or earlier if the pin rises first. The device stays in standby while the pin remains low. After the pin rises, a wake-up interval must pass before the device is ready again. Writes are locked out in three cases: while the supply flag is set, during and after reset until ready returns, and after power-up. After any lockout, a write is accepted only once the write condition has been seen broken at least once. If a hardware reset lands while a program operation is busy, a sticky flag records that the targeted location may hold corrupt data.

All ports are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake.

Top module: `flash_bus_guard`

## Requirements
- R1: The write condition is chip-enable low, write-enable low and output-enable high, all after filtering. When write-enable rises while chip-enable is still low and output-enable still high, `wr_strobe` is high for exactly one cycle, provided the condition held from the start of the write cycle.
- R2: If chip-enable rises, or output-enable falls, before write-enable rises, the write cycle is abandoned and no strobe is produced.
- R3: A low pulse shorter than `GLITCH_CYC` cycles on chip-enable, output-enable or write-enable is ignored. It neither starts nor breaks a write cycle.
- R4: After `rst_n` is released, a write condition that is already present produces no strobe when write-enable rises. Later complete write cycles are accepted.
- R5: While `vcc_low` is 1, `csm_rst` is held high and no strobe is produced. A write cycle that was already in progress when the flag cleared produces no strobe. The next complete cycle does.
- R6: A low pulse on `hw_rst_n` shorter than `MIN_PW_CYC` cycles produces no `csm_rst` pulse and does not lower `ready`.
- R7: A valid reset pulse produces exactly one `csm_rst` pulse. It comes about `RST_DLY_CYC` cycles after the pin falls, or as soon as the pin rises if the pin rises earlier.
- R8: `dout_en` is 0 while the synchronised `hw_rst_n` is low.
- R9: Once a valid reset has started, and until `ready` returns, all write cycles are ignored.
- R10: After the reset pin rises, `ready` stays 0 for `WAKE_CYC` cycles and then returns to 1.
- R11: `data_suspect` is set when the reset pulse from the hardware reset occurs while `prog_busy` is 1. It stays set until `rst_n` is asserted.
- R12: When the device is ready and the pins show chip-enable low, output-enable low and write-enable high, `dout_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Power-on reset, active low |
| ce_n | input | 1 | Chip-enable pin, active low |
| oe_n | input | 1 | Output-enable pin, active low |
| we_n | input | 1 | Write-enable pin, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| vcc_low | input | 1 | Supply below lockout level |
| prog_busy | input | 1 | Program operation in progress, from the command state machine |
| wr_strobe | output | 1 | One-cycle qualified write pulse |
| csm_rst | output | 1 | Reset request to the command state machine |
| dout_en | output | 1 | Enable for the tristate data drivers |
| ready | output | 1 | Device accessible |
| data_suspect | output | 1 | Sticky flag: a reset interrupted a program operation |

## Verification
The hardest states to reach from the ports are the lockout exits where a write condition was already active when the lockout ended. These occur at power-up, and when the supply flag clears while chip-enable and write-enable are still low. Reaching them takes deliberate ordering of the stimulus. The bench holds the pins in the write condition across the release of `rst_n` or `vcc_low`, and only then raises write-enable. It repeats this for the case where a reset interrupts a busy program operation, and for a reset pin released before the reset delay has run out.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  typedef enum logic [2:0] {
    RS_RUN,
    RS_PEND,
    RS_ARMED,
    RS_STANDBY,
    RS_WAKE
  } rst_state_e;
endpackage

// File: rtl/fbg_sync.sv
module fbg_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fbg_glitch_filt.sv
module fbg_glitch_filt #(
  parameter int   HOLD_CYC = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt <= RST_VAL;
      cnt  <= '0;
    end else if (raw == filt) begin
      cnt <= '0;
    end else if (cnt == CW'(HOLD_CYC - 1)) begin
      filt <= raw;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_FILT_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt) |-> (filt == $past(raw))); // R3
endmodule

// File: rtl/fbg_rst_seq.sv
module fbg_rst_seq
  import fbg_pkg::*;
#(
  parameter int MIN_PW_CYC  = 100,
  parameter int RST_DLY_CYC = 4000000,
  parameter int WAKE_CYC    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic ready,
  output logic csm_pulse
);
  localparam int MAXC = (RST_DLY_CYC > WAKE_CYC) ? RST_DLY_CYC : WAKE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  rst_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RS_RUN;
      cnt       <= '0;
      csm_pulse <= 1'b0;
    end else begin
      csm_pulse <= 1'b0;
      unique case (state)
        RS_RUN: if (!pin) begin
          state <= RS_PEND;
          cnt   <= CW'(1);
        end
        RS_PEND: if (pin) begin
          state <= RS_RUN;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(MIN_PW_CYC - 1)) state <= RS_ARMED;
        end
        RS_ARMED: if (pin) begin
          csm_pulse <= 1'b1;
          state     <= RS_WAKE;
          cnt       <= '0;
        end else if (cnt == CW'(RST_DLY_CYC - 1)) begin
          csm_pulse <= 1'b1;
          state     <= RS_STANDBY;
          cnt       <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        RS_STANDBY: if (pin) begin
          state <= RS_WAKE;
          cnt   <= '0;
        end
        RS_WAKE: if (!pin) begin
          state <= RS_PEND;
          cnt   <= CW'(1);
        end else if (cnt == CW'(WAKE_CYC - 1)) begin
          state <= RS_RUN;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= RS_RUN;
      endcase
    end
  end

  assign ready = (state == RS_RUN) || (state == RS_PEND);

  AST_RST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    csm_pulse |=> !csm_pulse); // R7
  AST_SHORT_PULSE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_PEND && pin) |=> (!csm_pulse && ready)); // R6
  AST_WAKE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RS_STANDBY && pin) |=> !ready); // R10
endmodule

// File: rtl/fbg_wr_qual.sv
module fbg_wr_qual #(
  parameter int SETTLE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_stb
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic [SW-1:0] scnt;
  logic          settled, armed, in_wr, cond, en_eff;

  assign settled = (scnt == SW'(SETTLE_CYC));
  assign en_eff  = en && settled;
  assign cond    = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt   <= '0;
      armed  <= 1'b0;
      in_wr  <= 1'b0;
      wr_stb <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (!settled) scnt <= scnt + 1'b1;
      if (!en_eff) begin
        armed <= 1'b0;
        in_wr <= 1'b0;
      end else begin
        if (!cond) armed <= 1'b1;
        if (in_wr) begin
          if (!cond) begin
            in_wr  <= 1'b0;
            wr_stb <= !ce_n && oe_n && we_n;
          end
        end else if (cond && armed) begin
          in_wr <= 1'b1;
        end
      end
    end
  end

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R1
  AST_STROBE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> armed); // R4
endmodule

// File: rtl/flash_bus_guard.sv
module flash_bus_guard #(
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYC  = 2,
  parameter int MIN_PW_CYC  = 100,
  parameter int RST_DLY_CYC = 4000000,
  parameter int WAKE_CYC    = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic hw_rst_n,
  input  logic vcc_low,
  input  logic prog_busy,
  output logic wr_strobe,
  output logic csm_rst,
  output logic dout_en,
  output logic ready,
  output logic data_suspect
);
  localparam int NPIN   = 3;
  localparam int SETTLE = SYNC_STAGES + GLITCH_CYC + 2;

  logic [NPIN+1:0] raw_s;
  logic [NPIN-1:0] pin_f;
  logic            rst_pin_s, lock_s, seq_ready, csm_pulse;
  logic            ce_f, oe_f, we_f;

  fbg_sync #(.W(NPIN + 2), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({vcc_low, hw_rst_n, we_n, oe_n, ce_n}),
    .q(raw_s)
  );

  assign lock_s    = raw_s[NPIN+1];
  assign rst_pin_s = raw_s[NPIN];

  for (genvar g = 0; g < NPIN; g++) begin : g_filt
    fbg_glitch_filt #(.HOLD_CYC(GLITCH_CYC), .RST_VAL(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw(raw_s[g]), .filt(pin_f[g])
    );
  end

  assign ce_f = pin_f[0];
  assign oe_f = pin_f[1];
  assign we_f = pin_f[2];

  fbg_rst_seq #(
    .MIN_PW_CYC(MIN_PW_CYC), .RST_DLY_CYC(RST_DLY_CYC), .WAKE_CYC(WAKE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pin(rst_pin_s),
    .ready(seq_ready), .csm_pulse(csm_pulse)
  );

  fbg_wr_qual #(.SETTLE_CYC(SETTLE)) u_wq (
    .clk(clk), .rst_n(rst_n), .en(seq_ready && !lock_s),
    .ce_n(ce_f), .oe_n(oe_f), .we_n(we_f), .wr_stb(wr_strobe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_en      <= 1'b0;
      data_suspect <= 1'b0;
    end else begin
      dout_en <= seq_ready && rst_pin_s && !ce_f && !oe_f && we_f;
      if (csm_pulse && prog_busy) data_suspect <= 1'b1;
    end
  end

  assign csm_rst = csm_pulse || lock_s;
  assign ready   = seq_ready;

  AST_NO_WRITE_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    lock_s |=> !wr_strobe); // R5
  AST_NO_WRITE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_ready |=> !wr_strobe); // R9
  AST_DOUT_OFF_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pin_s |=> !dout_en); // R8
  AST_SUSPECT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    data_suspect |=> data_suspect); // R11
endmodule

// File: tb/tb_flash_bus_guard.sv
`timescale 1ns/1ps
module tb_flash_bus_guard;
  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n, hw_rst_n, vcc_low, prog_busy;
  logic wr_strobe, csm_rst, dout_en, ready, data_suspect;

  int n_chk = 0, n_fail = 0;
  int n_wr = 0, n_csm = 0;
  logic csm_prev = 1'b0;

  always #2.5 clk = ~clk;

  flash_bus_guard #(
    .SYNC_STAGES(2), .GLITCH_CYC(2), .MIN_PW_CYC(8), .RST_DLY_CYC(20), .WAKE_CYC(10)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .hw_rst_n(hw_rst_n), .vcc_low(vcc_low), .prog_busy(prog_busy),
    .wr_strobe(wr_strobe), .csm_rst(csm_rst), .dout_en(dout_en),
    .ready(ready), .data_suspect(data_suspect)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_strobe) n_wr++;
      if (csm_rst && !csm_prev) n_csm++;
    end
    csm_prev = csm_rst;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic full_write();
    ce_n = 0; oe_n = 1; cyc(6);
    we_n = 0; cyc(6);
    we_n = 1; cyc(6);
    ce_n = 1; cyc(6);
  endtask

  task automatic t_powerup();
    int w0;
    rst_n = 0; ce_n = 0; oe_n = 1; we_n = 0; hw_rst_n = 1; vcc_low = 0; prog_busy = 0;
    cyc(5);
    chk("R4 reset wr_strobe", wr_strobe, 0);
    chk("R11 reset data_suspect", data_suspect, 0);
    chk("R8 reset dout_en", dout_en, 0);
    rst_n = 1; cyc(14);
    w0 = n_wr;
    we_n = 1; cyc(8);
    chk("R4 no strobe after power-up", n_wr - w0, 0);
    chk("R10 ready after power-up", ready, 1);
    ce_n = 1; cyc(6);
    w0 = n_wr; full_write();
    chk("R4 later write accepted", n_wr - w0, 1);
  endtask

  task automatic t_basic_write();
    int w0 = n_wr;
    full_write(); full_write();
    chk("R1 two writes give two strobes", n_wr - w0, 2);
  endtask

  task automatic t_abort();
    int w0 = n_wr;
    ce_n = 0; oe_n = 1; we_n = 0; cyc(6);
    oe_n = 0; cyc(6); we_n = 1; cyc(6);
    oe_n = 1; ce_n = 1; cyc(6);
    chk("R2 OE fall aborts", n_wr - w0, 0);
    w0 = n_wr;
    ce_n = 0; we_n = 0; cyc(6);
    ce_n = 1; cyc(6); we_n = 1; cyc(6);
    chk("R2 CE rise aborts", n_wr - w0, 0);
  endtask

  task automatic t_glitch();
    int w0 = n_wr;
    ce_n = 0; oe_n = 1; we_n = 1; cyc(6);
    we_n = 0; cyc(1); we_n = 1; cyc(10);
    chk("R3 short WE pulse ignored", n_wr - w0, 0);
    ce_n = 1; cyc(6);
    w0 = n_wr;
    we_n = 0; cyc(6);
    ce_n = 0; cyc(1); ce_n = 1; cyc(6);
    we_n = 1; cyc(6);
    chk("R3 short CE pulse ignored", n_wr - w0, 0);
    w0 = n_wr;
    ce_n = 0; we_n = 0; cyc(6);
    oe_n = 0; cyc(1); oe_n = 1; cyc(6);
    we_n = 1; cyc(6); ce_n = 1; cyc(6);
    chk("R3 short OE pulse does not abort", n_wr - w0, 1);
  endtask

  task automatic t_lockout();
    int w0;
    vcc_low = 1; cyc(6);
    chk("R5 csm_rst held in lockout", csm_rst, 1);
    w0 = n_wr; full_write();
    chk("R5 write ignored in lockout", n_wr - w0, 0);
    ce_n = 0; oe_n = 1; we_n = 0; cyc(6);
    vcc_low = 0; cyc(10);
    chk("R5 csm_rst released", csm_rst, 0);
    w0 = n_wr;
    we_n = 1; cyc(6); ce_n = 1; cyc(6);
    chk("R5 pending cycle rejected after lockout", n_wr - w0, 0);
    w0 = n_wr; full_write();
    chk("R5 write after lockout accepted", n_wr - w0, 1);
  endtask

  task automatic t_short_reset();
    int c0;
    ce_n = 0; oe_n = 0; we_n = 1; cyc(8);
    chk("R12 read enables drivers", dout_en, 1);
    c0 = n_csm;
    hw_rst_n = 0; cyc(4);
    chk("R8 drivers off during short pulse", dout_en, 0);
    cyc(1); hw_rst_n = 1; cyc(30);
    chk("R6 short pulse no csm reset", n_csm - c0, 0);
    chk("R6 short pulse keeps ready", ready, 1);
    chk("R12 drivers back after short pulse", dout_en, 1);
  endtask

  task automatic t_long_reset();
    int c0 = n_csm;
    int w0;
    hw_rst_n = 0; cyc(5);
    chk("R8 drivers off during reset", dout_en, 0);
    cyc(10);
    chk("R7 no csm reset before delay", n_csm - c0, 0);
    cyc(15);
    chk("R7 one csm reset after delay", n_csm - c0, 1);
    chk("R9 not ready in standby", ready, 0);
    w0 = n_wr;
    oe_n = 1; ce_n = 0; we_n = 0; cyc(6);
    we_n = 1; cyc(6); ce_n = 1; cyc(10);
    chk("R9 write ignored in standby", n_wr - w0, 0);
    hw_rst_n = 1; cyc(5);
    chk("R10 not ready during wake", ready, 0);
    cyc(15);
    chk("R10 ready after wake", ready, 1);
    chk("R7 single csm reset", n_csm - c0, 1);
    chk("R11 no suspect without busy", data_suspect, 0);
  endtask

  task automatic t_early_release();
    int c0 = n_csm;
    prog_busy = 1;
    hw_rst_n = 0; cyc(12);
    hw_rst_n = 1; cyc(4);
    prog_busy = 0; cyc(26);
    chk("R7 early release gives csm reset", n_csm - c0, 1);
    chk("R10 ready after early release", ready, 1);
    chk("R11 suspect set by reset during program", data_suspect, 1);
    cyc(10);
    chk("R11 suspect sticky", data_suspect, 1);
    rst_n = 0; cyc(3);
    chk("R11 suspect cleared by power-on reset", data_suspect, 0);
    rst_n = 1; cyc(10);
  endtask

  initial begin
    t_powerup();
    t_basic_write();
    t_abort();
    t_glitch();
    t_lockout();
    t_short_reset();
    t_long_reset();
    t_early_release();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule